// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block picks one of two reference clocks and forwards it on a single output to a downstream clock consumer such as a synthesizer. A free-running monitor clock samples both references. Per-input activity detectors flag any reference that has stopped toggling.

A selection state machine decides which reference is active. It has three modes, chosen by a static configuration input:
- automatic failover;
- manual toggling through a qualified request pin;
- automatic failover that a held request overrides and freezes.

The forwarded clock passes through a glitch-free multiplexer. That multiplexer releases the old source on its falling edge before it admits the new one on that clock's falling edge.

The monitor clock must run at more than twice the frequency of either reference. The request pin may be fully asynchronous. The outputs report which input is active and which inputs are flagged as stopped.

Top module: `refclk_switch`

## Requirements
- R1: After reset, `sel_active` is 0, `src_bad` is 2'b00, and `clk_out` carries `src_clk0`.
- R2: `clk_out` never shows a high or low phase shorter than the shorter half-period of the two inputs. The two internal lane enables are never high together.
- R3: `src_bad[i]` is set at the end of a window of `WIN_CYC` monitor cycles (default 16) in which fewer than 2 transitions of input i were sampled. It is cleared at the end of a window with 2 or more transitions. It changes only at window ends.
- R4: In mode 2'b00 (automatic), the selection toggles when the active input is flagged bad and the other is not. In this mode `swap_req` has no effect, and the selection does not move while the active input is good.
- R5: In automatic mode, when both inputs are flagged bad, the selection stays where it is.
- R6: In mode 2'b01 (manual), a request toggles `sel_active` once `swap_req` has been sampled high on 3 consecutive monitor edges after a low. The toggle lands on the 5th monitor rising edge, counting the first edge that samples the request high (2 synchronizer stages plus the 3-cycle hold). Stopped clocks cause no switch in this mode.
- R7: A request that is high for only 2 monitor cycles causes no switch.
- R8: One long request produces exactly one toggle. The request must return low before another toggle can be qualified.
- R9: In modes 2'b10 and 2'b11 (override), a qualified request toggles the selection. While the synchronized request is high, no other switch of any kind happens, even if the active input has failed.
- R10: In override mode with the request low, automatic failover works as in R4.
- R11: Some time after a switch, `clk_out` has the period of the newly selected input. This also holds when the previously selected input has stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock, faster than 2x either reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk0 | input | 1 | Reference clock input 0 |
| src_clk1 | input | 1 | Reference clock input 1 |
| mode_sel | input | 2 | Static mode: 00 automatic, 01 manual, 10/11 automatic with manual override |
| swap_req | input | 1 | Asynchronous switch request |
| clk_out | output | 1 | Forwarded reference clock |
| sel_active | output | 1 | Active input: 0 for src_clk0, 1 for src_clk1 |
| src_bad | output | 2 | Per-input stopped-clock flags, bit i for src_clk i |

## Verification
Request-driven toggles are due on the 5th monitor rising edge after the request is first sampled high. A reference model in the bench delays the sampled request by two edges, counts the hold itself, and compares `sel_active` at every falling monitor edge while no clock is failing.

Clock-bad flags and the failovers that follow them are due within two windows plus three synchronizer cycles of a clock stopping or restarting. The bench therefore checks them 60 monitor cycles after each stimulus.

Output handover completes within two falling edges of each reference. Period measurements on `clk_out` are taken only after that margin. A pulse-width monitor runs across every switch to catch short phases.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO    = 2'b00,
    MODE_MANUAL  = 2'b01,
    MODE_OVR     = 2'b10,
    MODE_OVR_ALT = 2'b11
  } mode_e;

  // transitions needed inside one window to call a reference alive
  localparam int MIN_EDGES = 2;

  // saturating two-bit transition accumulator
  function automatic logic [1:0] edge_acc(logic [1:0] n, logic t);
    if (t && (n != 2'd3)) return n + 2'd1;
    return n;
  endfunction

  // verdict at window end, including the transition seen in that last cycle
  function automatic logic window_bad(logic [1:0] n, logic t);
    return edge_acc(n, t) < 2'(MIN_EDGES);
  endfunction

  // next selection from mode, qualified request, raw synced request and flags
  function automatic logic next_sel(mode_e m, logic cur, logic fire,
                                    logic req_hi, logic [1:0] bad);
    logic fail;
    fail = bad[cur] && !bad[~cur];
    unique case (m)
      MODE_AUTO:   return fail ? ~cur : cur;
      MODE_MANUAL: return fire ? ~cur : cur;
      default:     return (fire || (!req_hi && fail)) ? ~cur : cur;
    endcase
  endfunction

endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon
  import refsw_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic src_clk,
  output logic src_bad
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

  logic [2:0]    smp_q;
  logic [CW-1:0] win_q;
  logic [1:0]    edges_q;
  logic          tog;
  logic          win_end;

  assign tog     = smp_q[2] ^ smp_q[1];
  assign win_end = (win_q == CW'(WIN_CYC - 1));

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      win_q   <= '0;
      edges_q <= '0;
      src_bad <= 1'b0;
    end else begin
      smp_q <= {smp_q[1:0], src_clk};
      if (win_end) begin
        src_bad <= window_bad(edges_q, tog);
        edges_q <= '0;
        win_q   <= '0;
      end else begin
        edges_q <= edge_acc(edges_q, tog);
        win_q   <= win_q + 1'b1;
      end
    end
  end

  // R3
  flag_at_window_end_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !win_end |=> $stable(src_bad));

endmodule

// File: rtl/swap_req_qual.sv
module swap_req_qual #(
  parameter int HOLD_CYC = 3
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_sync,
  output logic fire
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [1:0]    sync_q;
  logic [HW-1:0] run_q;
  logic          armed_q;

  assign req_sync = sync_q[1];
  assign fire     = req_sync && armed_q && (run_q == HW'(HOLD_CYC - 1));

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      run_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], req_in};
      if (!req_sync) begin
        run_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (run_q != HW'(HOLD_CYC)) run_q <= run_q + 1'b1;
        if (fire) armed_q <= 1'b0;
      end
    end
  end

  // R6
  hold_before_fire_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    fire |-> $past(req_sync));

  // R8
  single_fire_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/swap_sel_ctrl.sv
module swap_sel_ctrl
  import refsw_pkg::*;
(
  input  logic       mon_clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic       fire,
  input  logic       req_sync,
  input  logic [1:0] src_bad,
  output logic       sel_q,
  output logic [1:0] kill_q
);
  logic sel_d;

  assign sel_d = next_sel(mode, sel_q, fire, req_sync, src_bad);

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      kill_q <= 2'b00;
    end else begin
      sel_q  <= sel_d;
      // a lane is forced off only when it is flagged dead and not selected
      kill_q <= src_bad & {~sel_q, sel_q};
    end
  end

  // R4
  auto_keep_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (mode == MODE_AUTO && !src_bad[sel_q]) |=> $stable(sel_q));

  // R5
  both_bad_keep_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (mode == MODE_AUTO && src_bad == 2'b11) |=> $stable(sel_q));

  // R6
  manual_only_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (mode == MODE_MANUAL && !fire) |=> $stable(sel_q));

  // R9
  ovr_freeze_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (mode[1] && req_sync && !fire) |=> $stable(sel_q));

  // R6
  fire_toggles_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (mode != MODE_AUTO && fire) |=> (sel_q != $past(sel_q)));

endmodule

// File: rtl/glitchless_mux.sv
module glitchless_mux (
  input  logic       rst_n,
  input  logic [1:0] src_clk,
  input  logic       sel,
  input  logic [1:0] kill,
  output logic       clk_out,
  output logic [1:0] lane_en
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [1:0] stg_q;
    logic       want;
    logic       clr;

    assign want = (sel == 1'(g)) && !lane_en[1-g];
    assign clr  = !rst_n || kill[g];

    always_ff @(negedge src_clk[g] or posedge clr) begin
      if (clr) stg_q <= 2'b00;
      else     stg_q <= {stg_q[0], want};
    end

    assign lane_en[g] = stg_q[1];
  end

  assign clk_out = |(src_clk & lane_en);

  // R2
  always_comb begin
    if (rst_n) begin
      one_lane_chk: assert (!(lane_en[0] && lane_en[1]));
    end
  end

endmodule

// File: rtl/refclk_switch.sv
module refclk_switch
  import refsw_pkg::*;
#(
  parameter int WIN_CYC  = 16,
  parameter int HOLD_CYC = 3
) (
  input  logic       mon_clk,
  input  logic       rst_n,
  input  logic       src_clk0,
  input  logic       src_clk1,
  input  logic [1:0] mode_sel,
  input  logic       swap_req,
  output logic       clk_out,
  output logic       sel_active,
  output logic [1:0] src_bad
);
  logic [1:0] src_vec;
  logic       req_sync;
  logic       fire;
  logic       sel_q;
  logic [1:0] kill;
  logic [1:0] lane_en;

  assign src_vec = {src_clk1, src_clk0};

  for (genvar g = 0; g < 2; g++) begin : g_mon
    clk_activity_mon #(.WIN_CYC(WIN_CYC)) i_mon (
      .mon_clk (mon_clk),
      .rst_n   (rst_n),
      .src_clk (src_vec[g]),
      .src_bad (src_bad[g])
    );
  end

  swap_req_qual #(.HOLD_CYC(HOLD_CYC)) i_qual (
    .mon_clk  (mon_clk),
    .rst_n    (rst_n),
    .req_in   (swap_req),
    .req_sync (req_sync),
    .fire     (fire)
  );

  swap_sel_ctrl i_ctrl (
    .mon_clk  (mon_clk),
    .rst_n    (rst_n),
    .mode     (mode_e'(mode_sel)),
    .fire     (fire),
    .req_sync (req_sync),
    .src_bad  (src_bad),
    .sel_q    (sel_q),
    .kill_q   (kill)
  );

  glitchless_mux i_mux (
    .rst_n   (rst_n),
    .src_clk (src_vec),
    .sel     (sel_q),
    .kill    (kill),
    .clk_out (clk_out),
    .lane_en (lane_en)
  );

  assign sel_active = sel_q;

endmodule

// File: tb/test_refclk_switch.sv
module test_refclk_switch;
  logic mon_clk = 1'b0;
  logic rst_n = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, run0 = 1'b1, run1 = 1'b1;
  logic swap_req = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic clk_out, sel_active;
  logic [1:0] src_bad;
  int checks = 0, errors = 0;
  bit done = 0;

  refclk_switch i_refclk_switch (
    .mon_clk(mon_clk), .rst_n(rst_n), .src_clk0(c0), .src_clk1(c1),
    .mode_sel(mode_sel), .swap_req(swap_req),
    .clk_out(clk_out), .sel_active(sel_active), .src_bad(src_bad));

  // 250 MHz monitor clock; references at 32 ns and 40 ns, offset from its edges
  always #2 mon_clk = ~mon_clk;
  initial begin #1; forever begin #16; if (run0) c0 = ~c0; end end
  initial begin #3; forever begin #20; if (run1) c1 = ~c1; end end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge mon_clk);
  endtask

  task automatic pulse(int n);
    @(negedge mon_clk); swap_req = 1'b1;
    cyc(n);
    swap_req = 1'b0;
  endtask

  task automatic period(output int p);
    realtime t1;
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); p = int'($realtime - t1);
  endtask

  // behavioural request model: two-edge delay line, run length, re-arm on low
  logic q[$];
  int   run_n;
  bit   armed;
  logic model_sel;
  bit   model_on = 0;
  always @(posedge mon_clk) begin
    if (!rst_n) begin
      q = '{1'b0, 1'b0}; run_n = 0; armed = 1; model_sel = 1'b0;
    end else begin
      logic s;
      s = q.pop_front();
      q.push_back(swap_req);
      if (s) begin
        if (armed && run_n == 2) begin
          armed = 0;
          if (mode_sel != 2'b00) model_sel = ~model_sel;
        end
        if (run_n < 3) run_n++;
      end else begin
        run_n = 0; armed = 1;
      end
    end
  end

  always @(negedge mon_clk)
    if (model_on && rst_n) chk("R6/R7/R8 per-cycle selection", sel_active, model_sel);

  // pulse-width monitor on the forwarded clock
  realtime last_t = 0;
  bit glitch_on = 0;
  int short_cnt = 0;
  always @(clk_out) begin
    if (glitch_on && ($realtime - last_t) < 15.0) short_cnt++;
    last_t = $realtime;
  end

  initial begin
    repeat (20000) @(posedge mon_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    cyc(5); rst_n = 1'b1;
    @(negedge mon_clk);
    chk("R1 reset selection", sel_active, 0);
    chk("R1 reset flags", src_bad, 0);
    model_on = 1;
    cyc(60); glitch_on = 1;
    chk("R3 both running", src_bad, 2'b00);
    period(p); chk("R1 output follows src_clk0", p, 32);

    pulse(2); cyc(12); chk("R7 short request ignored", sel_active, 0);
    pulse(3); cyc(12); chk("R6 manual toggle", sel_active, 1);
    cyc(60); period(p); chk("R11 output period after switch to 1", p, 40);
    pulse(40); cyc(12); chk("R8 long request single toggle", sel_active, 0);
    cyc(60); period(p); chk("R11 output period after switch to 0", p, 32);

    run0 = 1'b0; cyc(60);
    chk("R3 stopped clock flagged", src_bad, 2'b01);
    chk("R6 manual mode ignores failure", sel_active, 0);
    run0 = 1'b1; cyc(60);
    chk("R3 flag clears on restart", src_bad, 2'b00);

    model_on = 0; mode_sel = 2'b00;
    pulse(6); cyc(12); chk("R4 request ignored in auto", sel_active, 0);
    run0 = 1'b0; cyc(60);
    chk("R4 auto failover", sel_active, 1);
    chk("R3 flag on failed input", src_bad, 2'b01);
    cyc(40); period(p); chk("R11 output from survivor", p, 40);
    run0 = 1'b1; cyc(60);
    chk("R4 flags clear", src_bad, 2'b00);
    chk("R4 no return while active good", sel_active, 1);

    run0 = 1'b0; cyc(60);
    chk("R5 inactive failure keeps selection", sel_active, 1);
    run1 = 1'b0; cyc(60);
    chk("R5 both flagged", src_bad, 2'b11);
    chk("R5 both bad holds selection", sel_active, 1);
    run0 = 1'b1; run1 = 1'b1; cyc(80);
    chk("R3 both recovered", src_bad, 2'b00);

    mode_sel = 2'b10; swap_req = 1'b1; cyc(10);
    chk("R9 override request toggles", sel_active, 0);
    run0 = 1'b0; cyc(70);
    chk("R9 failure flagged under override", src_bad, 2'b01);
    chk("R9 selection frozen while request high", sel_active, 0);
    swap_req = 1'b0; cyc(10);
    chk("R10 failover after request release", sel_active, 1);
    cyc(40); period(p); chk("R11 output after override failover", p, 40);
    run0 = 1'b1; cyc(60);

    chk("R2 no short pulse on clk_out", short_cnt, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule